// File: doc/BRIEF.md
# Serial Audio Sample Negator

This block sits in a serial digital audio path, between a receiver and a converter, and flips the absolute polarity of the signal. The input is a framed stream of signed 16-bit two's-complement samples. It arrives on a serial data line together with a word/channel select line. The block's clock is the bit clock, so one bit moves per rising edge. Words arrive least significant bit first, which lets the plus-one of a true negation ripple through a single carry flag instead of a parallel adder.

When the negate input is high, each word leaves the block as its exact arithmetic negation: the complement plus one, not the complement alone. The one code with no positive counterpart, the most negative value, is clamped to the largest positive value. When the negate input is low, words pass through untouched. The minimum code can only be recognised once its final bit has arrived, so every word is held in a one-word shift buffer. The channel select is delayed by the same amount. Both outputs come straight from flops, so the output stream is reclocked after the logic.

Top module: `serial_sample_negator`

## Requirements
- R1: With the negate setting latched low for a word, the output word equals the input word bit for bit.
- R2: With the negate setting latched high, any input word other than 0x8000 is output as its two's-complement negation modulo 2^16. For example, 0x0000 gives 0x0000, 0x0001 gives 0xFFFF, 0xFFFF gives 0x0001, and 0x7FFF gives 0x8001.
- R3: With the negate setting latched high, input 0x8000 is output as 0x7FFF. With it latched low, 0x8000 passes as 0x8000.
- R4: The negate input is sampled only on the first bit of each word. A change later in that word has no effect on that word and applies from the next word.
- R5: Serial format. sd_i is sampled on each rising clk edge, least significant bit first, 16 bits per word. A word begins on the edge where ws_i differs from its value at the previous edge. The output stream uses the same format on sd_o and ws_o.
- R6: Each output bit, and ws_o, appears exactly 16 rising edges after the edge that sampled the matching input. ws_o therefore carries the channel level of the word being output.
- R7: The negation state is cleared at every word start, so a word's result does not depend on the word before it.
- R8: While rst_n is low, sd_o and ws_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| neg_i | input | 1 | Polarity select: 1 negates, 0 passes through |
| ws_i | input | 1 | Word/channel select of the incoming stream |
| sd_i | input | 1 | Incoming serial data, LSB first |
| ws_o | output | 1 | Word/channel select, delayed one word |
| sd_o | output | 1 | Outgoing serial data, LSB first, registered |

## Verification
Every result is due a fixed 16 edges after its stimulus. If the bench drives bit 0 of a word on the falling edge while its cycle counter reads c, that bit is sampled at count c+1. The same bit reaches sd_o at edge c+17, when ws_o also switches to that word's channel level. The bench rebuilds output words from the ws_o transitions and samples at falling edges, halfway between updates. For each word it checks the value, the channel level, and that the start count minus the drive count is exactly 17. The negate setting for each word is taken from its state at bit 0. In the mid-word flip scenarios, the word being sent keeps its old setting and only the next word follows the new one.

// File: rtl/serial_sample_negator.sv
module serial_sample_negator #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] SAT = {1'b0, {(W-1){1'b1}}};

  logic          ws_prev, pol_q, seen_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  word_q, wsd_q;

  wire          start = ws_i ^ ws_prev;
  wire          pol   = start ? neg_i : pol_q;
  wire          seen  = start ? 1'b0 : seen_q;
  wire [CW-1:0] idx   = start ? '0 : cnt_q;
  wire          last  = (idx == CW'(W-1));
  wire          nbit  = sd_i ^ (pol & seen);
  wire          sat   = pol & last & sd_i & ~seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      pol_q   <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      word_q  <= '0;
      wsd_q   <= '0;
      sd_o    <= 1'b0;
      ws_o    <= 1'b0;
    end else begin
      ws_prev <= ws_i;
      pol_q   <= pol;
      seen_q  <= seen | sd_i;
      cnt_q   <= last ? '0 : idx + CW'(1);
      word_q  <= sat ? SAT : {nbit, word_q[W-1:1]};
      wsd_q   <= {ws_i, wsd_q[W-1:1]};
      sd_o    <= word_q[0];
      ws_o    <= wsd_q[0];
    end
  end
endmodule

// File: rtl/serial_sample_negator_chk.sv
module serial_sample_negator_chk #(
  parameter int W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ws_i,
  input logic                  sd_i,
  input logic                  ws_o,
  input logic                  sd_o,
  input logic                  pol_q,
  input logic                  seen_q,
  input logic [$clog2(W)-1:0]  cnt_q
);
  logic         warm;
  logic [W:0]   hist;
  int           hv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm <= 1'b0;
      hist <= '0;
      hv   <= 0;
    end else begin
      warm <= 1'b1;
      hist <= {hist[W-1:0], ws_i};
      if (hv < W + 1) hv <= hv + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r8_reset_out: assert (sd_o == 1'b0 && ws_o == 1'b0);
    end
  end

  a_r6_ws_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (hv == W + 1) |-> (ws_o == hist[W]));

  a_r4_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ws_i == $past(ws_i)) |=> $stable(pol_q));

  a_r5_word_start: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ws_i != $past(ws_i)) |=> (cnt_q == 1));

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ws_i != $past(ws_i) && !sd_i) |=> !seen_q);
endmodule

bind serial_sample_negator serial_sample_negator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ws_i(ws_i), .sd_i(sd_i), .ws_o(ws_o),
  .sd_o(sd_o), .pol_q(pol_q), .seen_q(seen_q), .cnt_q(cnt_q)
);

// File: tb/tb_serial_sample_negator.sv
module tb_serial_sample_negator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic neg_i = 1'b0;
  logic ws_i = 1'b0;
  logic sd_i = 1'b0;
  logic ws_o, sd_o;

  always #4 clk = ~clk;

  serial_sample_negator dut (
    .clk(clk), .rst_n(rst_n), .neg_i(neg_i), .ws_i(ws_i),
    .sd_i(sd_i), .ws_o(ws_o), .sd_o(sd_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic ws_cur = 1'b0;

  logic [15:0] exp_v[$];
  logic        exp_w[$];
  int          exp_c[$];
  string       exp_r[$];
  logic [15:0] rcv_v[$];
  logic        rcv_w[$];
  int          rcv_c[$];

  always @(posedge clk) cyc <= cyc + 1;

  // output deserializer
  logic        m_prev = 1'b0;
  logic        m_act = 1'b0;
  int          m_n = 0;
  int          m_c = 0;
  logic [15:0] m_v = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ws_o != m_prev) begin
        m_v = '0;
        m_v[0] = sd_o;
        m_n = 1;
        m_c = cyc;
        m_act = 1'b1;
      end else if (m_act && m_n < 16) begin
        m_v[m_n] = sd_o;
        m_n = m_n + 1;
      end
      if (m_act && m_n == 16) begin
        rcv_v.push_back(m_v);
        rcv_w.push_back(ws_o);
        rcv_c.push_back(m_c);
        m_act = 1'b0;
      end
      m_prev = ws_o;
    end
  end

  function automatic logic [15:0] ref_neg(logic [15:0] v);
    return (v == 16'h8000) ? 16'h7FFF : (~v + 16'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // drive one word; polarity flips from bit flip_at onward when flip_at >= 0
  task automatic send_word(input logic [15:0] v, input logic neg,
                           input int flip_at, input string req);
    ws_cur = ~ws_cur;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 0) begin
        exp_v.push_back(neg ? ref_neg(v) : v);
        exp_w.push_back(ws_cur);
        exp_c.push_back(cyc);
        exp_r.push_back(req);
      end
      neg_i = (flip_at >= 0 && i >= flip_at) ? ~neg : neg;
      ws_i  = ws_cur;
      sd_i  = v[i];
    end
  endtask

  task automatic drain();
    repeat (20) @(negedge clk) sd_i = 1'b0;
    while (exp_v.size() > 0) begin
      if (rcv_v.size() == 0) begin
        chk(1'b0, exp_r[0], "word missing", 0, exp_v[0]);
        void'(exp_v.pop_front()); void'(exp_w.pop_front());
        void'(exp_c.pop_front()); void'(exp_r.pop_front());
      end else begin
        logic [15:0] ev, rv;
        logic ew, rw;
        int ec, rc;
        string rq;
        ev = exp_v.pop_front(); ew = exp_w.pop_front();
        ec = exp_c.pop_front(); rq = exp_r.pop_front();
        rv = rcv_v.pop_front(); rw = rcv_w.pop_front(); rc = rcv_c.pop_front();
        chk(rv == ev, rq, "word value", rv, ev);
        chk(rw == ew, "R6", "channel level", rw, ew);
        chk(rc - ec == 17, "R6", "latency", rc - ec, 17);
      end
    end
    rcv_v.delete(); rcv_w.delete(); rcv_c.delete();
  endtask

  task automatic t_reset();
    chk(sd_o == 1'b0, "R8", "sd_o after reset", sd_o, 0);
    chk(ws_o == 1'b0, "R8", "ws_o after reset", ws_o, 0);
  endtask

  task automatic t_pass();
    send_word(16'h1234, 1'b0, -1, "R1");
    send_word(16'hA5C3, 1'b0, -1, "R1");
    send_word(16'h8000, 1'b0, -1, "R3");
    send_word(16'hFFFF, 1'b0, -1, "R5");
    for (int k = 0; k < 8; k++) send_word(16'($urandom), 1'b0, -1, "R1");
    drain();
  endtask

  task automatic t_corners();
    send_word(16'h0000, 1'b1, -1, "R2");
    send_word(16'h0001, 1'b1, -1, "R2");
    send_word(16'hFFFF, 1'b1, -1, "R2");
    send_word(16'h7FFF, 1'b1, -1, "R2");
    send_word(16'h8000, 1'b1, -1, "R3");
    send_word(16'h8001, 1'b1, -1, "R2");
    send_word(16'h8000, 1'b1, -1, "R3");
    send_word(16'h0100, 1'b1, -1, "R5");
    drain();
  endtask

  task automatic t_random_neg();
    for (int k = 0; k < 40; k++) send_word(16'($urandom), 1'b1, -1, "R2");
    for (int k = 0; k < 20; k++) send_word(16'($urandom), k[0], -1, "R2");
    drain();
  endtask

  task automatic t_mid_flip();
    send_word(16'h00F0, 1'b0, 7, "R4");
    send_word(16'h00F0, 1'b1, -1, "R4");
    send_word(16'h1235, 1'b1, 3, "R4");
    send_word(16'h1235, 1'b0, -1, "R4");
    send_word(16'h8000, 1'b0, 15, "R4");
    drain();
  endtask

  task automatic t_word_clear();
    send_word(16'h0001, 1'b1, -1, "R7");
    send_word(16'h0000, 1'b1, -1, "R7");
    send_word(16'h0002, 1'b1, -1, "R7");
    send_word(16'h8000, 1'b1, -1, "R7");
    send_word(16'h8000, 1'b1, -1, "R7");
    send_word(16'h0000, 1'b1, -1, "R7");
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_corners();
    t_random_neg();
    t_mid_flip();
    t_word_clear();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule